// File: doc/BRIEF.md
# Accumulator-Based Bus Sequencing Controller

This block is a small list-driven controller that acts as the master on a Wishbone bus. It reads 32-bit operation words one after another from a synchronous instruction memory. It uses these words to move data between bus addresses through a single accumulator, to write constants, to pause for a set number of clock cycles, and to hand the accumulator to an external control port. The block has no functional unit. It cannot do arithmetic, compare values or branch on a condition, so a program always runs straight through and wraps from the last instruction address back to zero.

Each word carries a 4-bit opcode in its top bits and a 28-bit operand below it. For the three bus operations, the operand shifted left by four gives the byte address. An immediate write takes its data from the word that follows it in memory, and the controller steps past that word. Typical uses are start-up configuration of peripherals, polling-free register shuffles, and paced streams of register writes.

Top module: `bus_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `imem_addr` is 0, `wb_cyc_o` and `ctl_valid_o` are low, and the accumulator is cleared, so a hand-off executed before any bus read delivers 0.
- R2: An operation word holds its opcode in bits 31:28 and its operand in bits 27:0. The bus address of opcodes 0001, 0010 and 0011 is the operand shifted left by 4.
- R3: Opcode 0001 performs one bus write to the operand address with `wb_we_o`=1, `wb_sel_o`=4'hF and data taken from the next instruction word. That word is then skipped and never executed.
- R4: Opcode 0010 performs one bus read (`wb_we_o`=0) and loads `wb_dat_i`, sampled with `wb_ack_i`, into the accumulator.
- R5: Opcode 0011 performs one bus write of the accumulator value to the operand address.
- R6: Opcode 0100 places the accumulator on `ctl_data_o` with `ctl_valid_o` high for exactly one cycle. The sequence then continues at the next word.
- R7: Opcode 1000 stalls for exactly as many extra cycles as its operand. An operand of 0 adds none.
- R8: Opcode 0000 and every opcode not named above take two cycles. They start no bus transfer and leave the accumulator unchanged.
- R9: A transfer raises `wb_cyc_o` and `wb_stb_o` together and holds them, the address, the data and `wb_we_o` steady until `wb_ack_i` is seen. The strobes then drop at the next edge and stay low for at least two cycles.
- R10: The instruction address advances by one per consumed word and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction memory word address |
| imem_rdata | input | 32 | Instruction word, valid one cycle after its address |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | 4 | Byte selects, all ones |
| wb_adr_o | output | 32 | Byte address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Transfer acknowledge |
| ctl_data_o | output | 32 | Accumulator value handed to the controller |
| ctl_valid_o | output | 1 | One-cycle qualifier for `ctl_data_o` |

## Verification
Every instruction spends one cycle presenting its address and one cycle decoding. A bus transfer's strobes rise at the edge that ends decoding (for an immediate write, two cycles later) and last one cycle plus the slave's extra acknowledge delay. With a slave that acknowledges in the first strobe cycle, the bench therefore expects exact gaps between transfer starts: 3, 5 and 7 cycles in the fixed part of the program, 7 plus the delay operand across the stall, and 47 across the tail of NOPs and the wrap. Each gap grows by the slave delay. Transfers and hand-off pulses are logged on the falling clock edge, where every registered output has settled, and the gaps are compared after the run for each delay operand from 0 to 7 and each slave delay from 0 to 3.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 4;
  localparam int OPND_W = WORD_W - OPC_W;
  localparam int SEL_W  = WORD_W / 8;

  localparam logic [OPC_W-1:0] OPC_IDLE  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_PUTK  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'b0011;
  localparam logic [OPC_W-1:0] OPC_HAND  = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_DELAY = 4'b1000;

  typedef enum logic [2:0] {
    K_IDLE, K_PUTK, K_LOAD, K_STORE, K_HAND, K_DELAY
  } op_kind_t;

  typedef struct packed {
    op_kind_t            kind;
    logic [WORD_W-1:0]   adr;
    logic [OPND_W-1:0]   count;
  } op_dec_t;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_IMM_ADDR, S_IMM_DATA, S_BUS, S_STALL
  } seq_state_t;
endpackage

// File: rtl/seq_decoder.sv
module seq_decoder
  import seq_pkg::*;
#(
  parameter int ADDR_SHIFT = 4
) (
  input  logic [WORD_W-1:0] word_i,
  output op_dec_t           dec_o
);
  logic [OPC_W-1:0]  opc;
  logic [OPND_W-1:0] opnd;

  assign opc  = word_i[WORD_W-1 -: OPC_W];
  assign opnd = word_i[OPND_W-1:0];

  always_comb begin
    dec_o.adr   = WORD_W'(opnd) << ADDR_SHIFT;
    dec_o.count = opnd;
    unique case (opc)
      OPC_PUTK:  dec_o.kind = K_PUTK;
      OPC_LOAD:  dec_o.kind = K_LOAD;
      OPC_STORE: dec_o.kind = K_STORE;
      OPC_HAND:  dec_o.kind = K_HAND;
      OPC_DELAY: dec_o.kind = K_DELAY;
      default:   dec_o.kind = K_IDLE;
    endcase
  end
endmodule

// File: rtl/seq_delay_timer.sv
module seq_delay_timer #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/seq_wb_master.sv
module seq_wb_master
  import seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              start_we_i,
  input  logic [WORD_W-1:0] start_adr_i,
  input  logic [WORD_W-1:0] start_dat_i,
  input  logic              ack_i,
  output logic              cyc_o,
  output logic              stb_o,
  output logic              we_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [WORD_W-1:0] adr_o,
  output logic [WORD_W-1:0] dat_o,
  output logic              done_o
);
  logic cyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= 1'b0;
      we_o  <= 1'b0;
      adr_o <= '0;
      dat_o <= '0;
    end else if (start_i) begin
      cyc_q <= 1'b1;
      we_o  <= start_we_i;
      adr_o <= start_adr_i;
      dat_o <= start_dat_i;
    end else if (cyc_q && ack_i) begin
      cyc_q <= 1'b0;
    end
  end

  assign cyc_o  = cyc_q;
  assign stb_o  = cyc_q;
  assign sel_o  = {SEL_W{1'b1}};
  assign done_o = cyc_q && ack_i;
endmodule

// File: rtl/bus_sequencer.sv
module bus_sequencer
  import seq_pkg::*;
#(
  parameter int PC_W       = 10,
  parameter int ADDR_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [3:0]        wb_sel_o,
  output logic [31:0]       wb_adr_o,
  output logic [31:0]       wb_dat_o,
  input  logic [31:0]       wb_dat_i,
  input  logic              wb_ack_i,
  output logic [31:0]       ctl_data_o,
  output logic              ctl_valid_o
);
  seq_state_t        state_q;
  logic [PC_W-1:0]   pc_q;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] pend_adr_q;
  op_dec_t           dec;

  logic              xfer_start;
  logic              xfer_we;
  logic [WORD_W-1:0] xfer_adr;
  logic [WORD_W-1:0] xfer_dat;
  logic              xfer_done;
  logic              tmr_load;
  logic              tmr_last;

  seq_decoder #(.ADDR_SHIFT(ADDR_SHIFT)) u_dec (
    .word_i (imem_rdata),
    .dec_o  (dec)
  );

  seq_delay_timer #(.CNT_W(OPND_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (dec.count),
    .last_o     (tmr_last)
  );

  seq_wb_master u_wb (
    .clk         (clk),
    .rst         (rst),
    .start_i     (xfer_start),
    .start_we_i  (xfer_we),
    .start_adr_i (xfer_adr),
    .start_dat_i (xfer_dat),
    .ack_i       (wb_ack_i),
    .cyc_o       (wb_cyc_o),
    .stb_o       (wb_stb_o),
    .we_o        (wb_we_o),
    .sel_o       (wb_sel_o),
    .adr_o       (wb_adr_o),
    .dat_o       (wb_dat_o),
    .done_o      (xfer_done)
  );

  always_comb begin
    xfer_start = 1'b0;
    xfer_we    = 1'b0;
    xfer_adr   = dec.adr;
    xfer_dat   = acc_q;
    if (state_q == S_DECODE && (dec.kind == K_LOAD || dec.kind == K_STORE)) begin
      xfer_start = 1'b1;
      xfer_we    = (dec.kind == K_STORE);
    end else if (state_q == S_IMM_DATA) begin
      xfer_start = 1'b1;
      xfer_we    = 1'b1;
      xfer_adr   = pend_adr_q;
      xfer_dat   = imem_rdata;
    end
  end

  assign tmr_load = (state_q == S_DECODE) && (dec.kind == K_DELAY) && (dec.count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_FETCH;
      pc_q        <= '0;
      acc_q       <= '0;
      pend_adr_q  <= '0;
      ctl_data_o  <= '0;
      ctl_valid_o <= 1'b0;
    end else begin
      ctl_valid_o <= 1'b0;
      unique case (state_q)
        S_FETCH: state_q <= S_DECODE;
        S_DECODE: begin
          pc_q <= pc_q + 1'b1;
          unique case (dec.kind)
            K_PUTK: begin
              pend_adr_q <= dec.adr;
              state_q    <= S_IMM_ADDR;
            end
            K_LOAD, K_STORE: state_q <= S_BUS;
            K_HAND: begin
              ctl_data_o  <= acc_q;
              ctl_valid_o <= 1'b1;
              state_q     <= S_FETCH;
            end
            K_DELAY: state_q <= (dec.count == '0) ? S_FETCH : S_STALL;
            default: state_q <= S_FETCH;
          endcase
        end
        S_IMM_ADDR: state_q <= S_IMM_DATA;
        S_IMM_DATA: begin
          pc_q    <= pc_q + 1'b1;
          state_q <= S_BUS;
        end
        S_BUS: begin
          if (xfer_done) begin
            if (!wb_we_o) acc_q <= wb_dat_i;
            state_q <= S_FETCH;
          end
        end
        S_STALL: if (tmr_last) state_q <= S_FETCH;
        default: state_q <= S_FETCH;
      endcase
    end
  end

  assign imem_addr = pc_q;
endmodule

// File: rtl/bus_sequencer_checker.sv
module bus_sequencer_checker #(
  parameter int PC_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] imem_addr,
  input logic            wb_cyc_o,
  input logic            wb_we_o,
  input logic [31:0]     wb_adr_o,
  input logic [31:0]     wb_dat_o,
  input logic            wb_ack_i,
  input logic            ctl_valid_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (imem_addr == '0 && !wb_cyc_o && !ctl_valid_o));

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

  a_r9_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o);

  a_r9_idle_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(wb_cyc_o) |=> !wb_cyc_o);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    ctl_valid_o |=> !ctl_valid_o);

  a_r6_handoff_off_bus: assert property (@(posedge clk) disable iff (rst)
    ctl_valid_o |-> !wb_cyc_o);

  a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
    (imem_addr != $past(imem_addr)) |-> (imem_addr == PC_W'($past(imem_addr) + 1'b1)));
endmodule

bind bus_sequencer bus_sequencer_checker #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .imem_addr   (imem_addr),
  .wb_cyc_o    (wb_cyc_o),
  .wb_we_o     (wb_we_o),
  .wb_adr_o    (wb_adr_o),
  .wb_dat_o    (wb_dat_o),
  .wb_ack_i    (wb_ack_i),
  .ctl_valid_o (ctl_valid_o)
);

// File: tb/bus_sequencer_test.sv
module bus_sequencer_test;
  localparam int PC_W = 5;
  localparam int DEPTH = 1 << PC_W;
  localparam logic [31:0] KEY = 32'h5A5A_1234;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] imem_addr;
  logic [31:0] imem_rdata = '0;
  logic wb_cyc_o, wb_stb_o, wb_we_o;
  logic [3:0] wb_sel_o;
  logic [31:0] wb_adr_o, wb_dat_o, wb_dat_i;
  logic wb_ack_i = 1'b0;
  logic [31:0] ctl_data_o;
  logic ctl_valid_o;

  bus_sequencer #(.PC_W(PC_W)) uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i),
    .ctl_data_o(ctl_data_o), .ctl_valid_o(ctl_valid_o)
  );

  always #10 clk = ~clk;

  logic [31:0] mem [DEPTH];
  always @(posedge clk) imem_rdata <= mem[imem_addr];
  assign wb_dat_i = wb_adr_o ^ KEY;

  int cnum = 0;
  always @(posedge clk) cnum <= cnum + 1;

  int n_chk = 0, n_fail = 0;
  int ack_delay = 0, wcnt = 0;
  logic prev_cyc = 1'b0;
  int nlog = 0, nctl = 0;
  logic [31:0] lg_adr [8];
  logic [31:0] lg_dat [8];
  logic        lg_we  [8];
  logic [3:0]  lg_sel [8];
  logic        lg_stb [8];
  int          lg_t   [8];
  logic [31:0] ct_dat [8];

  always @(negedge clk) begin
    if (rst) begin
      wb_ack_i <= 1'b0; wcnt <= 0; prev_cyc <= 1'b0;
    end else begin
      if (wb_cyc_o && !prev_cyc && nlog < 8) begin
        lg_adr[nlog] <= wb_adr_o; lg_dat[nlog] <= wb_dat_o; lg_we[nlog] <= wb_we_o;
        lg_sel[nlog] <= wb_sel_o; lg_stb[nlog] <= wb_stb_o; lg_t[nlog] <= cnum;
        nlog <= nlog + 1;
      end
      if (ctl_valid_o && nctl < 8) begin
        ct_dat[nctl] <= ctl_data_o; nctl <= nctl + 1;
      end
      prev_cyc <= wb_cyc_o;
      if (wb_cyc_o && !wb_ack_i) begin
        if (wcnt == ack_delay) begin wb_ack_i <= 1'b1; wcnt <= 0; end
        else wcnt <= wcnt + 1;
      end else wb_ack_i <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w(input logic [3:0] op, input logic [27:0] v);
    return {op, v};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 addr", 32'(imem_addr), 0);
    check("R1 cyc", 32'(wb_cyc_o), 0);
    check("R1 valid", 32'(ctl_valid_o), 0);
    nlog = 0; nctl = 0;
    rst = 1'b0;
  endtask

  task automatic run_main(input int n, input int d);
    int guard;
    logic [31:0] acc;
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    mem[0]  = w(4'h1, 28'h10);  mem[1] = 32'hDEAD_BEEF;
    mem[2]  = w(4'h2, 28'h20);
    mem[3]  = w(4'h4, 28'h0);
    mem[4]  = w(4'h3, 28'h30);
    mem[5]  = 32'hF123_4567;
    mem[6]  = w(4'h8, 28'h0);
    mem[7]  = w(4'h3, 28'h31);
    mem[8]  = w(4'h8, 28'(n));
    mem[9]  = w(4'h1, 28'h40);  mem[10] = 32'h1234_5678;
    mem[11] = w(4'h4, 28'h0);
    ack_delay = d;
    do_reset();
    guard = 0;
    while (nlog < 6 && guard < 2000) begin @(negedge clk); guard++; end
    if (nlog < 6) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=6 transfers", nlog);
      return;
    end
    acc = 32'h200 ^ KEY;
    check("R3 adr", lg_adr[0], 32'h100);    check("R3 data", lg_dat[0], 32'hDEAD_BEEF);
    check("R3 we", 32'(lg_we[0]), 1);       check("R3 sel", 32'(lg_sel[0]), 32'hF);
    check("R9 stb", 32'(lg_stb[0]), 1);
    check("R4 adr", lg_adr[1], 32'h200);    check("R4 we", 32'(lg_we[1]), 0);
    check("R5 adr", lg_adr[2], 32'h300);    check("R5 data", lg_dat[2], acc);
    check("R2 adr", lg_adr[3], 32'h310);    check("R8 acc kept", lg_dat[3], acc);
    check("R3 skip adr", lg_adr[4], 32'h400); check("R3 skip data", lg_dat[4], 32'h1234_5678);
    check("R10 wrap adr", lg_adr[5], 32'h100);
    check("R4 gap", 32'(lg_t[1] - lg_t[0]), 32'(3 + d));
    check("R6 gap", 32'(lg_t[2] - lg_t[1]), 32'(5 + d));
    check("R8 R7 zero wait gap", 32'(lg_t[3] - lg_t[2]), 32'(7 + d));
    check("R7 wait gap", 32'(lg_t[4] - lg_t[3]), 32'(n + 7 + d));
    check("R10 wrap gap", 32'(lg_t[5] - lg_t[4]), 32'(47 + d));
    check("R6 pulses", 32'(nctl), 2);
    check("R6 data0", ct_dat[0], acc);      check("R6 data1", ct_dat[1], acc);
  endtask

  initial begin
    for (int n = 0; n < 8; n++) run_main(n, 0);
    for (int d = 1; d < 4; d++) run_main(2, d);
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    mem[0] = w(4'h4, 28'h0);
    ack_delay = 0;
    do_reset();
    repeat (10) @(negedge clk);
    check("R1 acc cleared pulses", 32'(nctl), 1);
    check("R1 acc cleared", ct_dat[0], 32'h0);
    check("R8 no bus", 32'(nlog), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule